// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit decides whether a conditional branch of a 32-bit processor is taken and produces the program counter that follows it. A request carries the branch instruction word, the optional second instruction word (an offset or an absolute address), the value of a general register, the current PC and the status-flag byte. The instruction selects a set of flags in an 8-bit condition mask. It chooses whether the target operand comes from the register or from the second word. It also chooses whether the operand is added to the PC or replaces it.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel through a single registered stage. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is presented from the following cycle. `req_ready` is high whenever the result register is empty or its content is being consumed in the same cycle. A presented result stays unchanged until `rsp_ready` is seen high. A request may be held with `req_valid` high for as long as needed. Its fields must stay stable until it is accepted.

Top module: `brt_branch_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `rsp_valid` is low and `req_ready` is high.
- R2: The condition mask is instruction bits 20 down to 13. Mask bit k selects flag bit k, with 1 = carry, 2 = divide-by-zero, 3 = not-equal, 4 = equal, 5 = greater-than, 6 = less-than and 7 = overflow. A nonzero mask makes the branch taken when any selected flag is set, so several conditions can be tested at once.
- R3: A mask of all zeros makes the branch taken whatever the flags are.
- R4: Flag bit 0 is reserved. A mask whose only set bit is bit 0 never makes the branch taken, even with every flag set.
- R5: Instruction bit 23 set takes the target operand from the register input and treats the branch as one word long. Bit 23 clear takes the operand from the second word and treats the branch as two words long.
- R6: Instruction bit 24 set selects an absolute branch: a taken branch yields the operand itself as the next PC.
- R7: Instruction bit 24 clear selects a relative branch: a taken branch yields PC + operand − 1 modulo 2^32, so an offset of −1234 moves the PC back by 1235.
- R8: A branch that is not taken yields PC + 1 (register form) or PC + 2 (second-word form), modulo 2^32.
- R9: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. An accepted request shows its result, with `rsp_valid` high, on the next cycle.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_taken` and `rsp_pc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_instr | input | 32 | Branch instruction word |
| req_ext | input | 32 | Second instruction word (offset or address) |
| req_reg | input | 32 | Register operand value |
| req_pc | input | 32 | PC of the branch instruction |
| req_flags | input | 8 | Status-flag byte |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_taken | output | 1 | Branch is taken |
| rsp_pc | output | 32 | Next program counter |

## Verification
The assertions check on every cycle the rules of the result channel. An accepted request always yields a result on the next cycle, and a stalled result never changes. They also check that an all-zero mask always branches, that a reserved-only mask never does, and that the fall-through PC of any untaken branch is the PC plus the instruction length. The correctness of taken targets needs the bench's scenarios, which compare every result against an independent model. These scenarios cover absolute and relative targets from both operand sources, multi-flag masks, negative offsets, and wrap-around at the top of the address space, all under random back-pressure.

// File: rtl/brt_pkg.sv
package brt_pkg;

  localparam int BRT_XLEN = 32;
  localparam int BRT_FLAG_W = 8;

  typedef logic [BRT_XLEN-1:0] brt_word_t;

  typedef enum logic {
    BRT_SRC_EXT = 1'b0,
    BRT_SRC_REG = 1'b1
  } brt_src_e;

  typedef enum logic {
    BRT_MODE_REL = 1'b0,
    BRT_MODE_ABS = 1'b1
  } brt_mode_e;

  typedef struct packed {
    logic      taken;
    brt_word_t next_pc;
  } brt_result_t;

  // flag bit positions; bit 0 is reserved and never tested
  localparam int BRT_FLG_RSVD  = 0;
  localparam int BRT_FLG_CARRY = 1;
  localparam int BRT_FLG_DIVZ  = 2;
  localparam int BRT_FLG_NEQ   = 3;
  localparam int BRT_FLG_EQ    = 4;
  localparam int BRT_FLG_GT    = 5;
  localparam int BRT_FLG_LT    = 6;
  localparam int BRT_FLG_OVF   = 7;

endpackage

// File: rtl/brt_cond_eval.sv
module brt_cond_eval #(
  parameter int MASK_W = 8,
  parameter logic [MASK_W-1:0] RSVD_BITS = 1
) (
  input  logic [MASK_W-1:0] cond_mask,
  input  logic [MASK_W-1:0] flags,
  output logic              cond_taken
);

  logic [MASK_W-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_bit
      if (RSVD_BITS[g]) begin : g_rsvd
        assign hit[g] = 1'b0;
      end else begin : g_live
        assign hit[g] = cond_mask[g] & flags[g];
      end
    end
  endgenerate

  always_comb begin
    cond_taken = (cond_mask == '0) || (|hit);
  end

endmodule

// File: rtl/brt_target_calc.sv
module brt_target_calc
  import brt_pkg::*;
#(
  parameter int REL_BIAS = -1
) (
  input  brt_src_e  src_sel,
  input  brt_mode_e mode,
  input  logic      taken,
  input  brt_word_t ext_word,
  input  brt_word_t reg_word,
  input  brt_word_t pc,
  output brt_word_t next_pc
);

  localparam brt_word_t BIAS_W = brt_word_t'(REL_BIAS);
  localparam brt_word_t STEP_REG = brt_word_t'(1);
  localparam brt_word_t STEP_EXT = brt_word_t'(2);

  brt_word_t operand;
  brt_word_t rel_tgt;
  brt_word_t seq_pc;

  always_comb begin
    operand = (src_sel == BRT_SRC_REG) ? reg_word : ext_word;
    rel_tgt = pc + operand + BIAS_W;
    seq_pc  = pc + ((src_sel == BRT_SRC_REG) ? STEP_REG : STEP_EXT);
    if (!taken) begin
      next_pc = seq_pc;
    end else if (mode == BRT_MODE_ABS) begin
      next_pc = operand;
    end else begin
      next_pc = rel_tgt;
    end
  end

endmodule

// File: rtl/brt_out_stage.sv
module brt_out_stage
  import brt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  brt_result_t in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output brt_result_t out_data
);

  logic fire_in;

  assign in_ready = !out_valid || out_ready;
  assign fire_in  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire_in) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("stalled result changed"); // R10

endmodule

// File: rtl/brt_branch_unit.sv
module brt_branch_unit
  import brt_pkg::*;
#(
  parameter int MASK_LSB = 13,
  parameter int MASK_W   = 8,
  parameter int SRC_BIT  = 23,
  parameter int MODE_BIT = 24,
  parameter int REL_BIAS = -1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_instr,
  input  logic [31:0] req_ext,
  input  logic [31:0] req_reg,
  input  logic [31:0] req_pc,
  input  logic [7:0]  req_flags,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_taken,
  output logic [31:0] rsp_pc
);

  localparam int MASK_MSB = MASK_LSB + MASK_W - 1;
  localparam logic [31:0] USED_BITS =
    (((32'd1 << MASK_W) - 32'd1) << MASK_LSB) | (32'd1 << SRC_BIT) | (32'd1 << MODE_BIT);
  localparam logic [MASK_W-1:0] RSVD = MASK_W'(1) << BRT_FLG_RSVD;

  logic [MASK_W-1:0] cond_mask;
  brt_src_e          src_sel;
  brt_mode_e         mode;
  logic              cond_taken;
  brt_word_t         next_pc;
  brt_result_t       res_in;
  brt_result_t       res_out;
  logic              unused_instr_bits;

  assign cond_mask = req_instr[MASK_MSB:MASK_LSB];
  assign src_sel   = brt_src_e'(req_instr[SRC_BIT]);
  assign mode      = brt_mode_e'(req_instr[MODE_BIT]);
  assign unused_instr_bits = ^(req_instr & ~USED_BITS);

  brt_cond_eval #(
    .MASK_W   (MASK_W),
    .RSVD_BITS(RSVD)
  ) u_cond (
    .cond_mask (cond_mask),
    .flags     (req_flags[MASK_W-1:0]),
    .cond_taken(cond_taken)
  );

  brt_target_calc #(
    .REL_BIAS(REL_BIAS)
  ) u_tgt (
    .src_sel (src_sel),
    .mode    (mode),
    .taken   (cond_taken),
    .ext_word(req_ext),
    .reg_word(req_reg),
    .pc      (req_pc),
    .next_pc (next_pc)
  );

  assign res_in.taken   = cond_taken;
  assign res_in.next_pc = next_pc;

  brt_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (res_in),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (res_out)
  );

  assign rsp_taken = res_out.taken;
  assign rsp_pc    = res_out.next_pc;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid) else $error("accepted request lost"); // R9

  AST_ZERO_MASK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cond_mask == '0) |=> rsp_taken) else $error("zero mask not taken"); // R3

  AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cond_mask == RSVD) |=> !rsp_taken) else $error("reserved flag took branch"); // R4

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cond_taken) |=>
      (rsp_pc == $past(req_pc) + ($past(req_instr[SRC_BIT]) ? 32'd1 : 32'd2))) else $error("bad fall-through pc"); // R8

endmodule

// File: tb/sim_brt_branch_unit.sv
module sim_brt_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_instr = '0;
  logic [31:0] req_ext = '0;
  logic [31:0] req_reg = '0;
  logic [31:0] req_pc = '0;
  logic [7:0]  req_flags = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_taken;
  logic [31:0] rsp_pc;

  always #10 clk = ~clk;

  brt_branch_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_ext(req_ext), .req_reg(req_reg),
    .req_pc(req_pc), .req_flags(req_flags),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_pc(rsp_pc)
  );

  localparam int N_ITEMS = 400;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int next_item = 0;
  bit done = 0;

  // behavioural model state
  bit          m_valid = 0;
  bit          m_taken = 0;
  logic [31:0] m_pc = '0;
  string       m_tag = "";
  bit          acc_last = 0;

  function automatic void model_eval(input logic [31:0] ins, input logic [31:0] ext,
                                     input logic [31:0] rg, input logic [31:0] pc,
                                     input logic [7:0] fl, output bit tk,
                                     output logic [31:0] npc, output string tag);
    logic [7:0] mask;
    logic [31:0] opnd;
    longint sum;
    mask = ins[20:13];
    tk = (mask == 0);
    for (int b = 1; b < 8; b++) if (mask[b] && fl[b]) tk = 1;
    opnd = ins[23] ? rg : ext;
    if (!tk) begin
      npc = pc + (ins[23] ? 1 : 2);
      tag = "R8";
    end else if (ins[24]) begin
      npc = opnd;
      tag = ins[23] ? "R6 R5 reg" : "R6 R5 ext";
    end else begin
      sum = longint'(pc) + longint'(opnd) - 1;
      npc = sum[31:0];
      tag = ins[23] ? "R7 R5 reg" : "R7 R5 ext";
    end
    if (mask == 8'h00) tag = {tag, " R3"};
    else if (mask == 8'h01) tag = {tag, " R4"};
    else tag = {tag, " R2"};
  endfunction

  function automatic logic [31:0] mk_instr(input bit abs_m, input bit src_r, input logic [7:0] mask);
    return {7'd0, abs_m, src_r, 2'd0, mask, 13'd0};
  endfunction

  task automatic load_item(input int i);
    logic [7:0] mask;
    case (i)
      0: begin req_instr = mk_instr(0, 0, 8'h00); req_ext = -32'sd1234; req_pc = 32'd5000; req_flags = 8'h00; end
      1: begin req_instr = mk_instr(1, 1, 8'h08); req_reg = 32'h1234; req_pc = 32'd40; req_flags = 8'h08; end
      2: begin req_instr = mk_instr(0, 0, 8'h08); req_ext = 32'd77; req_pc = 32'd600; req_flags = 8'h10; end
      3: begin req_instr = mk_instr(0, 1, 8'h01); req_reg = 32'd9; req_pc = 32'd700; req_flags = 8'hFF; end
      4: begin req_instr = mk_instr(0, 1, 8'h60); req_reg = 32'd10; req_pc = 32'd100; req_flags = 8'h40; end
      5: begin req_instr = mk_instr(0, 0, 8'h80); req_ext = 32'd5; req_pc = 32'hFFFF_FFFE; req_flags = 8'h80; end
      6: begin req_instr = mk_instr(1, 0, 8'h06); req_ext = 32'd3; req_pc = 32'hFFFF_FFFF; req_flags = 8'h39; end
      7: begin req_instr = mk_instr(1, 0, 8'h02); req_ext = 32'hDEAD_0000; req_pc = 32'd8; req_flags = 8'h02; end
      8: begin req_instr = mk_instr(1, 1, 8'h00); req_reg = 32'h0000_0100; req_pc = 32'd8; req_flags = 8'hFF; end
      9: begin req_instr = mk_instr(0, 1, 8'hFE); req_reg = 32'd1; req_pc = 32'd50; req_flags = 8'h01; end
      default: begin
        case ($urandom_range(0, 5))
          0: mask = 8'h00;
          1: mask = 8'h01;
          default: mask = 8'($urandom);
        endcase
        req_instr = mk_instr(1'($urandom), 1'($urandom), mask) | ($urandom & 32'hFE61_FFFF);
        req_ext = $urandom; req_reg = $urandom; req_pc = $urandom; req_flags = 8'($urandom);
      end
    endcase
  endtask

  // model update at the active edge; inputs only change at negedge
  always @(posedge clk) begin
    bit tk; logic [31:0] npc; string tg;
    acc_last = 0;
    if (!rst_n) begin
      m_valid = 0;
    end else if (req_valid && (!m_valid || rsp_ready)) begin
      model_eval(req_instr, req_ext, req_reg, req_pc, req_flags, tk, npc, tg);
      m_valid = 1; m_taken = tk; m_pc = npc; m_tag = tg;
      acc_last = 1;
    end else if (rsp_ready) begin
      m_valid = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    while (!done) begin
      cycles++;
      // compare every cycle against the model (R9, R10 and result values)
      chk(rsp_valid == m_valid, "R9 R10", "rsp_valid", 32'(rsp_valid), 32'(m_valid));
      chk(req_ready == (!m_valid || rsp_ready), "R9", "req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
      if (m_valid && rsp_valid) begin
        chk(rsp_taken == m_taken, m_tag, "rsp_taken", 32'(rsp_taken), 32'(m_taken));
        chk(rsp_pc == m_pc, m_tag, "rsp_pc", rsp_pc, m_pc);
      end
      // drive the next cycle's inputs
      rsp_ready = (cycles < 40) ? 1'b1 : ($urandom_range(0, 3) != 0);
      if (!req_valid || acc_last) begin
        if (next_item < N_ITEMS) begin
          load_item(next_item);
          next_item++;
          req_valid = (cycles % 7 != 3) || (next_item < 12);
          if (!req_valid) next_item--;
        end else begin
          req_valid = 1'b0;
          rsp_ready = 1'b1;
          if (!m_valid) done = 1;
        end
      end
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
        done = 1;
      end
      @(negedge clk);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule